// File: doc/BRIEF.md
# Byte-Wide EEPROM Page Program Controller

This block models the write side of a small parallel EEPROM holding 2048 bytes. The host drives chip-select, output-enable and write-enable, all active low, together with an 11-bit address and a data byte. Each rising edge of write-enable stores the byte in a page buffer. The edge counts only while chip-select is low and output-enable is high. The first stored byte fixes the page number, which is address bits 10..6. Later bytes join the same page as long as each one arrives within the load window after the previous strobe.

When the load window runs out without a new strobe, an internally timed program phase copies the stored bytes into the array in one step. The phase cannot be interrupted. If any byte in the burst named a different page, the whole burst is dropped and nothing is programmed. While programming is in progress, reads return a status word instead of array data, so the host polls the data bus to find out when the operation has finished.

The load window and the program time are parameters counted in clock cycles. All pins are sampled on the block's clock.

Top module: `eeprom_page_writer`

## Requirements
- R1: With chip-select low, output-enable low and write-enable high, the block drives the bus (`dq_oe`=1). Outside the program phase, `dq_out` carries the array byte at `addr`. After reset every array byte reads 8'hFF and the block is not programming.
- R2: With chip-select high, output-enable high, or write-enable low, `dq_oe` is 0.
- R3: A rising edge of write-enable, seen while chip-select is low and output-enable is high, stores `din` for `addr`. LOAD_CYCLES cycles after the last such edge, programming starts. After it completes, a read of that address returns the stored byte.
- R4: A burst can hold up to 64 bytes of one page. The page is addr[10:6] and the slot is addr[5:0]. All bytes of the burst are programmed by a single program phase.
- R5: If any byte in a burst has addr[10:6] different from the first byte of the burst, no byte of that burst is programmed.
- R6: The load window restarts at every strobe. Strobes spaced less than LOAD_CYCLES apart keep adding bytes to one burst, even when the whole burst lasts longer than LOAD_CYCLES.
- R7: During programming, a read returns bit 7 as the inverse of bit 7 of the last byte written, and bits 5..0 as 0.
- R8: During programming, bit 6 of the read value changes between one read access and the next.
- R9: Write strobes during programming are ignored. They neither change the array nor change the status bit 7.
- R10: Slots of a page that were not written in a burst keep their previous contents.
- R11: The program phase lasts exactly PROG_CYCLES cycles and always runs to completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip-select, active low |
| oe_n | input | 1 | Output-enable, active low |
| we_n | input | 1 | Write-enable, active low; a byte is stored on its rising edge |
| addr | input | 11 | Byte address; bits 10..6 select the page, bits 5..0 the slot |
| din | input | 8 | Write data |
| dq_out | output | 8 | Read data or busy status |
| dq_oe | output | 1 | High when the block drives the bus |

## Verification
The assertions assume that the pins change only between clock edges. They also assume that `addr` and `din` are stable in the cycle where write-enable rises, because that is the cycle in which the byte is captured. The bench drives every pin at the falling clock edge and holds address and data steady through each write-enable pulse. It holds each read access for several cycles, so a status toggle caused by the start of a read has settled before the value is sampled.

// File: rtl/eeprom_pkg.sv
`timescale 1ns/1ps
package eeprom_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_PROG = 2'd2
    } phase_e;
endpackage

// File: rtl/eeprom_strobe_decode.sv
`timescale 1ns/1ps
module eeprom_strobe_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic wr_strobe,
    output logic rd_active,
    output logic rd_start
);
    typedef struct packed {
        logic we;
        logic rd;
    } pin_t;

    pin_t pin_d, pin_q;

    always_comb begin
        rd_active = !ce_n && !oe_n && we_n;
        wr_strobe = !ce_n && oe_n && !pin_q.we && we_n;
        rd_start  = rd_active && !pin_q.rd;
        pin_d.we  = we_n;
        pin_d.rd  = rd_active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= '{we: 1'b1, rd: 1'b0};
        else        pin_q <= pin_d;
    end
endmodule

// File: rtl/eeprom_page_buffer.sv
`timescale 1ns/1ps
module eeprom_page_buffer #(
    parameter int SLOT_W = 6,
    parameter int DATA_W = 8,
    localparam int SLOTS = 1 << SLOT_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    load,
    input  logic [SLOT_W-1:0]       slot,
    input  logic [DATA_W-1:0]       wdata,
    output logic [SLOTS*DATA_W-1:0] bytes_flat,
    output logic [SLOTS-1:0]        valid
);
    logic [SLOTS*DATA_W-1:0] bytes_d, bytes_q;
    logic [SLOTS-1:0]        valid_d, valid_q;

    always_comb begin
        bytes_d = bytes_q;
        valid_d = clear ? '0 : valid_q;
        if (load) begin
            bytes_d[slot*DATA_W +: DATA_W] = wdata;
            valid_d[slot] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bytes_q <= '0;
            valid_q <= '0;
        end else begin
            bytes_q <= bytes_d;
            valid_q <= valid_d;
        end
    end

    assign bytes_flat = bytes_q;
    assign valid      = valid_q;
endmodule

// File: rtl/eeprom_array.sv
`timescale 1ns/1ps
module eeprom_array #(
    parameter int ADDR_W = 11,
    parameter int SLOT_W = 6,
    parameter int DATA_W = 8,
    localparam int SLOTS  = 1 << SLOT_W,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int PAGE_W = ADDR_W - SLOT_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    commit,
    input  logic [PAGE_W-1:0]       page,
    input  logic [SLOTS*DATA_W-1:0] bytes_flat,
    input  logic [SLOTS-1:0]        valid,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [DATA_W-1:0]       rdata
);
    logic [DATA_W-1:0] cells_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells_q[i] <= '1;
        end else if (commit) begin
            for (int s = 0; s < SLOTS; s++) begin
                if (valid[s]) cells_q[{page, SLOT_W'(s)}] <= bytes_flat[s*DATA_W +: DATA_W];
            end
        end
    end

    assign rdata = cells_q[raddr];
endmodule

// File: rtl/eeprom_page_writer.sv
`timescale 1ns/1ps
module eeprom_page_writer
    import eeprom_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int SLOT_W      = 6,
    parameter int DATA_W      = 8,
    parameter int LOAD_CYCLES = 100,
    parameter int PROG_CYCLES = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    localparam int SLOTS   = 1 << SLOT_W;
    localparam int PAGE_W  = ADDR_W - SLOT_W;
    localparam int MAX_CYC = (LOAD_CYCLES > PROG_CYCLES) ? LOAD_CYCLES : PROG_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   cnt;
        logic [PAGE_W-1:0]  page;
        logic               abort;
        logic [DATA_W-1:0]  last;
        logic               toggle;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic wr_strobe, rd_active, rd_start;
    logic buf_clear, buf_load, commit;
    logic busy, loading, aborted;
    logic [SLOTS*DATA_W-1:0] bytes_flat;
    logic [SLOTS-1:0]        valid;
    logic [DATA_W-1:0]       rdata;
    logic [PAGE_W-1:0]       in_page;

    assign in_page = addr[ADDR_W-1:SLOT_W];

    eeprom_strobe_decode u_dec (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .wr_strobe(wr_strobe), .rd_active(rd_active), .rd_start(rd_start)
    );

    eeprom_page_buffer #(.SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .clear(buf_clear), .load(buf_load),
        .slot(addr[SLOT_W-1:0]), .wdata(din),
        .bytes_flat(bytes_flat), .valid(valid)
    );

    eeprom_array #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .commit(commit), .page(ctl_q.page),
        .bytes_flat(bytes_flat), .valid(valid), .raddr(addr), .rdata(rdata)
    );

    always_comb begin
        ctl_d     = ctl_q;
        buf_clear = 1'b0;
        buf_load  = 1'b0;
        commit    = 1'b0;
        case (ctl_q.phase)
            PH_IDLE: begin
                if (wr_strobe) begin
                    ctl_d.phase = PH_LOAD;
                    ctl_d.cnt   = CNT_W'(LOAD_CYCLES - 1);
                    ctl_d.page  = in_page;
                    ctl_d.abort = 1'b0;
                    ctl_d.last  = din;
                    buf_clear   = 1'b1;
                    buf_load    = 1'b1;
                end
            end
            PH_LOAD: begin
                if (wr_strobe) begin
                    ctl_d.cnt  = CNT_W'(LOAD_CYCLES - 1);
                    ctl_d.last = din;
                    if (in_page != ctl_q.page) ctl_d.abort = 1'b1;
                    else if (!ctl_q.abort)     buf_load    = 1'b1;
                end else if (ctl_q.cnt == '0) begin
                    if (ctl_q.abort) begin
                        ctl_d.phase = PH_IDLE;
                    end else begin
                        ctl_d.phase = PH_PROG;
                        ctl_d.cnt   = CNT_W'(PROG_CYCLES - 1);
                    end
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            PH_PROG: begin
                if (rd_start) ctl_d.toggle = ~ctl_q.toggle;
                if (ctl_q.cnt == '0) begin
                    commit      = 1'b1;
                    ctl_d.phase = PH_IDLE;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            default: ctl_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{phase: PH_IDLE, default: '0};
        else        ctl_q <= ctl_d;
    end

    assign busy    = (ctl_q.phase == PH_PROG);
    assign loading = (ctl_q.phase == PH_LOAD);
    assign aborted = ctl_q.abort;
    assign dq_oe   = rd_active;
    assign dq_out  = busy ? {~ctl_q.last[DATA_W-1], ctl_q.toggle, {(DATA_W-2){1'b0}}}
                          : rdata;
endmodule

// File: rtl/eeprom_page_writer_chk.sv
`timescale 1ns/1ps
module eeprom_page_writer_chk #(
    parameter int PROG_CYCLES = 2000,
    parameter int DATA_W      = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic              dq_oe,
    input logic              busy,
    input logic              loading,
    input logic              aborted,
    input logic              commit,
    input logic              wr_strobe,
    input logic [DATA_W-1:0] dq_out
);
    int unsigned prog_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    prog_len <= 0;
        else if (busy) prog_len <= prog_len + 1;
        else           prog_len <= 0;
    end

    assert_float_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n || !we_n) |-> !dq_oe);

    assert_commit_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> busy);

    assert_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (loading && aborted) |=> !busy);

    assert_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && wr_strobe && !commit) |=> $stable(dq_out[DATA_W-1]));

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !commit) |=> busy);

    assert_len_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (prog_len == PROG_CYCLES));

    assert_max_R11: assert property (@(posedge clk) disable iff (!rst_n)
        prog_len <= PROG_CYCLES);
endmodule

bind eeprom_page_writer eeprom_page_writer_chk #(.PROG_CYCLES(PROG_CYCLES), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .dq_oe(dq_oe), .busy(busy), .loading(loading), .aborted(aborted),
    .commit(commit), .wr_strobe(wr_strobe), .dq_out(dq_out)
);

// File: tb/eeprom_page_writer_bench.sv
`timescale 1ns/1ps
module eeprom_page_writer_bench;
    localparam int LOAD = 100;
    localparam int PROG = 2000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [10:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dq_out;
    logic        dq_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    eeprom_page_writer #(.LOAD_CYCLES(LOAD), .PROG_CYCLES(PROG)) u_eeprom_page_writer (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_byte(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1; addr = a; din = d; we_n = 1'b0;
        idle_cycles(2);
        we_n = 1'b1;
        idle_cycles(1);
        ce_n = 1'b1;
    endtask

    task automatic read_byte(input logic [10:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
        idle_cycles(3);
        d = dq_out; oe = dq_oe;
        ce_n = 1'b1; oe_n = 1'b1;
        idle_cycles(2);
    endtask

    task automatic wait_done();
        idle_cycles(LOAD + PROG + 20);
    endtask

    task automatic t_reset();
        logic [7:0] d; logic oe;
        read_byte(11'h123, d, oe);
        check("R1 reset read", d, 8'hFF);
        check("R1 drive", {7'd0, oe}, 8'd1);
    endtask

    task automatic t_float();
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1;
        idle_cycles(1); check("R2 ce high", {7'd0, dq_oe}, 8'd0);
        ce_n = 1'b0; oe_n = 1'b1;
        idle_cycles(1); check("R2 oe high", {7'd0, dq_oe}, 8'd0);
        oe_n = 1'b0; we_n = 1'b0;
        idle_cycles(1); check("R2 we low", {7'd0, dq_oe}, 8'd0);
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        idle_cycles(2);
    endtask

    task automatic t_single();
        logic [7:0] d; logic oe;
        write_byte({5'd7, 6'd3}, 8'h5A);
        wait_done();
        read_byte({5'd7, 6'd3}, d, oe);
        check("R3 single byte", d, 8'h5A);
    endtask

    task automatic t_full_page();
        logic [7:0] d; logic oe;
        for (int i = 0; i < 64; i++) write_byte({5'd5, 6'(i)}, 8'(i) ^ 8'h3C);
        wait_done();
        for (int i = 0; i < 64; i++) begin
            read_byte({5'd5, 6'(i)}, d, oe);
            check("R4 full page", d, 8'(i) ^ 8'h3C);
        end
    endtask

    task automatic t_window();
        logic [7:0] d; logic oe;
        write_byte({5'd9, 6'd0}, 8'h10);
        idle_cycles(LOAD - 20);
        write_byte({5'd9, 6'd1}, 8'h11);
        idle_cycles(LOAD - 20);
        write_byte({5'd9, 6'd2}, 8'h12);
        wait_done();
        read_byte({5'd9, 6'd0}, d, oe); check("R6 first", d, 8'h10);
        read_byte({5'd9, 6'd2}, d, oe); check("R6 last", d, 8'h12);
    endtask

    task automatic t_abort();
        logic [7:0] d; logic oe;
        write_byte({5'd1, 6'd0}, 8'h11);
        write_byte({5'd2, 6'd0}, 8'h22);
        write_byte({5'd1, 6'd1}, 8'h33);
        wait_done();
        read_byte({5'd1, 6'd0}, d, oe); check("R5 abort first", d, 8'hFF);
        read_byte({5'd2, 6'd0}, d, oe); check("R5 abort other", d, 8'hFF);
        read_byte({5'd1, 6'd1}, d, oe); check("R5 abort later", d, 8'hFF);
    endtask

    task automatic t_busy();
        logic [7:0] d1, d2, d3; logic oe;
        write_byte({5'd7, 6'd4}, 8'hA5);
        idle_cycles(LOAD + 10);
        read_byte({5'd7, 6'd4}, d1, oe);
        check("R7 bit7 inverted", {7'd0, d1[7]}, 8'd0);
        check("R7 low bits zero", {2'b00, d1[5:0]}, 8'h00);
        read_byte({5'd7, 6'd4}, d2, oe);
        check("R8 toggle", {7'd0, d2[6]}, {7'd0, ~d1[6]});
        write_byte({5'd7, 6'd5}, 8'h00);
        read_byte({5'd7, 6'd4}, d3, oe);
        check("R9 status unchanged", {7'd0, d3[7]}, 8'd0);
        idle_cycles(PROG - 100);
        read_byte({5'd7, 6'd4}, d3, oe);
        check("R11 still busy", {d3[7], d3[5:0]}, 7'd0);
        idle_cycles(120);
        read_byte({5'd7, 6'd4}, d3, oe); check("R11 done data", d3, 8'hA5);
        read_byte({5'd7, 6'd5}, d3, oe); check("R9 ignored write", d3, 8'hFF);
        read_byte({5'd7, 6'd3}, d3, oe); check("R10 neighbour kept", d3, 8'h5A);
    endtask

    initial begin
        idle_cycles(3);
        rst_n = 1'b1;
        idle_cycles(2);
        t_reset();
        t_float();
        t_single();
        t_full_page();
        t_window();
        t_abort();
        t_busy();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule